// File: doc/BRIEF.md
# USB Host Interrupt Status Collector

This block gathers the global interrupt sources of a USB host controller into one 32-bit status word, together with a single interrupt line for the processor. The host state machinery drives one-cycle event pulses into it: a frame start was issued, a low-speed keep-alive was issued, a resume arrived from the device, a resume toward the device finished, a bus reset finished, a device attached, and a device detached. Up to nine pipe engines each supply a live interrupt level. Four mode inputs tell the block whether frame generation is stopped (suspended), whether the bus power request is active (operational), whether the port runs at low speed, and whether the main clock is frozen.

Software reaches the block through a plain register port. A write strobe, a 2-bit word address and write data carry writes. Read data is combinational on the address. Address 0 is the status word. Address 1 is a write-one-to-clear register. Address 2 is the interrupt enable register. This is control and status traffic, so there is no valid/ready handshake and no back-pressure. A write takes effect at the clock edge where the strobe is high.

The wakeup flag lives in an always-running part of the block. It still captures its set conditions while the main flag bank is frozen. Every other flag, the enable register and all register writes hold while the freeze input is high.

Top module: `usbh_irq_collector`

## Requirements
- R1: After reset the status word, the enable register and the interrupt output are all zero.
- R2: Status bit positions are fixed: 0 attach, 1 detach, 2 bus reset done, 3 resume sent, 4 resume received, 5 frame start, 6 wakeup, 8+n pipe n. Bit 7 and bits 17 to 31 read zero. The enable register reads back only those defined bits. Address 3 reads zero.
- R3: Each pipe bit is the live level of its pipe input in the same cycle. A clear-register write does not change it.
- R4: The wakeup flag sets on a resume received or a detach while suspended, or on an attach while operational. It sets on no other event.
- R5: While the freeze input is high, the wakeup flag still captures its set conditions. All other flags, the enable register and all register writes hold their values, and events on the other flags are not recorded.
- R6: The frame-start flag sets on every frame-start pulse. It also sets on a keep-alive pulse, but only when the low-speed input is high.
- R7: The attach, detach, bus reset done, resume sent and resume received flags each latch on their own event pulse, in any mode, and stay set.
- R8: Writing a one to a bit of the clear register (address 1) clears the matching flag at bits 0 to 6. Zero bits have no effect. Reading address 1 returns zero.
- R9: When a set event and a clear write reach the same flag in the same cycle, the flag ends set.
- R10: The interrupt output is high exactly when some status bit and its matching enable bit are both one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_freeze_i | input | 1 | Main clock frozen: flag bank and register writes hold |
| sof_gen_off_i | input | 1 | Suspended: frame generation stopped |
| vbus_req_i | input | 1 | Operational: bus power requested |
| low_speed_i | input | 1 | Port runs at low speed |
| ev_sof_i | input | 1 | Frame start issued (pulse) |
| ev_keepalive_i | input | 1 | Keep-alive issued (pulse) |
| ev_rsm_rx_i | input | 1 | Resume received from device (pulse) |
| ev_rsm_tx_done_i | input | 1 | Resume toward device finished (pulse) |
| ev_bus_rst_done_i | input | 1 | Bus reset finished (pulse) |
| ev_dev_conn_i | input | 1 | Device attached (pulse) |
| ev_dev_disc_i | input | 1 | Device detached (pulse) |
| pipe_irq_i | input | NUM_PIPES | Live per-pipe interrupt levels |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational on address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A latched flag appears in the status word one clock after the edge that sees its event pulse or clear write. A pipe bit, the read data and the interrupt output follow their inputs within the same cycle, because they are combinational. The bench drives inputs on the falling edge. Its behavioural model updates at each rising edge, and it compares the read data and the interrupt output 5 ns after that edge, so every result is sampled after the single register stage has settled. Directed checks read the status word on the falling edge that ends each stimulus task, which is the first point at which the new value is due.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;
  // Status bit positions decoded by software
  localparam int B_CONN   = 0;
  localparam int B_DISC   = 1;
  localparam int B_RST    = 2;
  localparam int B_RSMTX  = 3;
  localparam int B_RSMRX  = 4;
  localparam int B_SOF    = 5;
  localparam int B_WAKE   = 6;
  localparam int B_RSVD   = 7;
  localparam int NUM_EVT  = 6;   // flags held in the freezable bank
  localparam int PIPE_LSB = 8;

  typedef enum logic [1:0] {
    ADDR_STATUS = 2'd0,
    ADDR_CLEAR  = 2'd1,
    ADDR_ENABLE = 2'd2,
    ADDR_SPARE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/usbh_irq_evt_bank.sv
module usbh_irq_evt_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  // One sticky flag per event; run_i low models the frozen clock.
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flag_o[i] <= 1'b0;
      else if (run_i)
        flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && set_i[i]) |=> flag_o[i]); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && clr_i[i] && !set_i[i]) |=> !flag_o[i]); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[i] && !flag_o[i]) |=> !flag_o[i]); // R7
  end

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(flag_o)); // R5
endmodule

// File: rtl/usbh_irq_wake_flag.sv
module usbh_irq_wake_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // Clocked by the always-running clock, never gated by the freeze input.
  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_o <= 1'b0;
    else
      flag_o <= set_i | (flag_o & ~clr_i);
  end

  AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R5
  AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R8
  AST_WAKE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !flag_o) |=> !flag_o); // R4
endmodule

// File: rtl/usbh_irq_collector.sv
module usbh_irq_collector
  import usbh_irq_pkg::*;
#(
  parameter int NUM_PIPES = 9,   // PIPE_LSB + NUM_PIPES must not exceed DATA_W
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clk_freeze_i,
  input  logic                 sof_gen_off_i,
  input  logic                 vbus_req_i,
  input  logic                 low_speed_i,
  input  logic                 ev_sof_i,
  input  logic                 ev_keepalive_i,
  input  logic                 ev_rsm_rx_i,
  input  logic                 ev_rsm_tx_done_i,
  input  logic                 ev_bus_rst_done_i,
  input  logic                 ev_dev_conn_i,
  input  logic                 ev_dev_disc_i,
  input  logic [NUM_PIPES-1:0] pipe_irq_i,
  input  logic                 reg_wr_i,
  input  logic [1:0]           reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);
  localparam int PIPE_END = PIPE_LSB + NUM_PIPES;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] VALID_MASK =
    ((ONE << PIPE_END) - ONE) & ~(ONE << B_RSVD);

  logic               run;
  logic               clr_wr;
  logic [NUM_EVT-1:0] evt_set, evt_clr, evt_flags;
  logic               wake_set, wake_clr, wake_flag;
  logic [DATA_W-1:0]  en_q;
  logic [DATA_W-1:0]  status;

  assign run    = !clk_freeze_i;
  assign clr_wr = reg_wr_i && run && (reg_addr_i == ADDR_CLEAR);

  // Event sources for the freezable flags
  always_comb begin
    evt_set          = '0;
    evt_set[B_CONN]  = ev_dev_conn_i;
    evt_set[B_DISC]  = ev_dev_disc_i;
    evt_set[B_RST]   = ev_bus_rst_done_i;
    evt_set[B_RSMTX] = ev_rsm_tx_done_i;
    evt_set[B_RSMRX] = ev_rsm_rx_i;
    evt_set[B_SOF]   = ev_sof_i | (low_speed_i & ev_keepalive_i);
  end

  assign evt_clr  = clr_wr ? reg_wdata_i[NUM_EVT-1:0] : '0;
  assign wake_set = (sof_gen_off_i & (ev_rsm_rx_i | ev_dev_disc_i))
                  | (vbus_req_i & ev_dev_conn_i);
  assign wake_clr = clr_wr & reg_wdata_i[B_WAKE];

  usbh_irq_evt_bank #(.N(NUM_EVT)) evt_bank_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .flag_o (evt_flags)
  );

  usbh_irq_wake_flag wake_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (wake_set),
    .clr_i  (wake_clr),
    .flag_o (wake_flag)
  );

  // Enable register, frozen with the main domain
  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (reg_wr_i && run && (reg_addr_i == ADDR_ENABLE))
      en_q <= reg_wdata_i & VALID_MASK;
  end

  always_comb begin
    status                         = '0;
    status[NUM_EVT-1:0]            = evt_flags;
    status[B_WAKE]                 = wake_flag;
    status[PIPE_LSB +: NUM_PIPES]  = pipe_irq_i;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_STATUS: reg_rdata_o = status;
      ADDR_ENABLE: reg_rdata_o = en_q;
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(status & en_q);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_STATUS) |-> ((reg_rdata_o & ~VALID_MASK) == '0)); // R2
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_CLEAR) |-> (reg_rdata_o == '0)); // R8
  AST_PIPE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ADDR_STATUS) |-> (reg_rdata_o[PIPE_LSB +: NUM_PIPES] == pipe_irq_i)); // R3
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_o); // R10
  AST_ENABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    clk_freeze_i |=> $stable(en_q)); // R5
endmodule

// File: tb/usbh_irq_collector_tb.sv
module usbh_irq_collector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_freeze_i = 1'b0, sof_gen_off_i = 1'b0, vbus_req_i = 1'b0, low_speed_i = 1'b0;
  logic [6:0]  ev = '0; // 0 conn,1 disc,2 rst,3 rsm tx,4 rsm rx,5 sof,6 keepalive
  logic [8:0]  pipe_irq_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;

  always #10 clk = ~clk;

  usbh_irq_collector dut_i (
    .clk(clk), .rst_n(rst_n), .clk_freeze_i(clk_freeze_i),
    .sof_gen_off_i(sof_gen_off_i), .vbus_req_i(vbus_req_i), .low_speed_i(low_speed_i),
    .ev_sof_i(ev[5]), .ev_keepalive_i(ev[6]), .ev_rsm_rx_i(ev[4]),
    .ev_rsm_tx_done_i(ev[3]), .ev_bus_rst_done_i(ev[2]),
    .ev_dev_conn_i(ev[0]), .ev_dev_disc_i(ev[1]),
    .pipe_irq_i(pipe_irq_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [6:0]  m_flag; // bits 0..6 of the status word
  logic [31:0] m_en;
  logic [6:0]  m_set, m_clr;
  logic [31:0] m_stat, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = '0;
      m_en   = '0;
    end else begin
      m_set = {((sof_gen_off_i && (ev[4] || ev[1])) || (vbus_req_i && ev[0])),
               (ev[5] || (low_speed_i && ev[6])), ev[4:0]};
      m_clr = (reg_wr_i && !clk_freeze_i && reg_addr_i == 2'd1) ? reg_wdata_i[6:0] : 7'd0;
      if (!clk_freeze_i) begin
        m_flag[5:0] = m_set[5:0] | (m_flag[5:0] & ~m_clr[5:0]);
        if (reg_wr_i && reg_addr_i == 2'd2) m_en = reg_wdata_i & 32'h0001_FF7F;
      end
      m_flag[6] = m_set[6] | (m_flag[6] & ~m_clr[6]);
    end
  end

  // Per-cycle comparison 5 ns after each rising edge (R2, R10)
  always @(posedge clk) begin
    #5;
    if (live) begin
      m_stat = {15'd0, pipe_irq_i, 1'b0, m_flag};
      m_exp  = (reg_addr_i == 2'd0) ? m_stat : (reg_addr_i == 2'd2) ? m_en : 32'd0;
      checks++;
      if (reg_rdata_o !== m_exp) begin
        errors++;
        $display("FAIL R2 cycle model rdata: actual %h expected %h", reg_rdata_o, m_exp);
      end
      checks++;
      if (irq_o !== |(m_stat & m_en)) begin
        errors++;
        $display("FAIL R10 cycle model irq: actual %0b expected %0b", irq_o, |(m_stat & m_en));
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
    reg_addr_i = 2'd0;
    #1;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk) ev = m;
    @(negedge clk) ev = '0;
  endtask

  task automatic wr_ev(input logic [1:0] a, input logic [31:0] d, input logic [6:0] m);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; ev = m;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_addr_i = 2'd0; reg_wdata_i = '0; ev = '0;
  endtask

  task automatic stat_is(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(2'd0, v);
    chk(tag, v, exp);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live  = 1'b1;
    // R1 reset state
    stat_is("R1 status after reset", 32'h0);
    rd(2'd2, v); chk("R1 enable after reset", v, 32'h0);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);

    // R7 latched event flags, R4 no wake when idle mode
    pulse(7'h01); pulse(7'h02); pulse(7'h04); pulse(7'h08); pulse(7'h10);
    stat_is("R7 five flags latched, R4 wake stays low", 32'h1F);
    repeat (3) @(negedge clk);
    stat_is("R7 flags stay set", 32'h1F);

    // R8 write-one-to-clear
    wr_ev(2'd1, 32'h0, 7'h0);
    stat_is("R8 zero write no effect", 32'h1F);
    rd(2'd1, v); chk("R8 clear reads zero", v, 32'h0);
    wr_ev(2'd1, 32'h3, 7'h0);
    stat_is("R8 partial clear", 32'h1C);
    wr_ev(2'd1, 32'h1C, 7'h0);
    stat_is("R8 full clear", 32'h0);

    // R6 frame start and keep-alive
    pulse(7'h40);
    stat_is("R6 keep-alive ignored at full speed", 32'h0);
    pulse(7'h20);
    stat_is("R6 frame start sets", 32'h20);
    wr_ev(2'd1, 32'h20, 7'h0);
    low_speed_i = 1'b1;
    pulse(7'h40);
    stat_is("R6 keep-alive sets at low speed", 32'h20);
    wr_ev(2'd1, 32'h20, 7'h0);
    low_speed_i = 1'b0;

    // R4 wakeup set conditions
    sof_gen_off_i = 1'b1;
    pulse(7'h10);
    stat_is("R4 resume while suspended", 32'h50);
    wr_ev(2'd1, 32'h50, 7'h0);
    pulse(7'h02);
    stat_is("R4 detach while suspended", 32'h42);
    wr_ev(2'd1, 32'h42, 7'h0);
    pulse(7'h01);
    stat_is("R4 attach while suspended not operational", 32'h01);
    wr_ev(2'd1, 32'h01, 7'h0);
    sof_gen_off_i = 1'b0;
    vbus_req_i = 1'b1;
    pulse(7'h01);
    stat_is("R4 attach while operational", 32'h41);
    pulse(7'h12);
    stat_is("R4 resume/detach while operational no extra wake", 32'h53);
    wr_ev(2'd1, 32'h53, 7'h0);
    vbus_req_i = 1'b0;
    stat_is("R8 wake cleared", 32'h0);

    // R5 frozen clock
    clk_freeze_i = 1'b1;
    sof_gen_off_i = 1'b1;
    pulse(7'h02);
    stat_is("R5 wake captured while frozen", 32'h40);
    pulse(7'h24);
    stat_is("R5 other events lost while frozen", 32'h40);
    wr_ev(2'd1, 32'h40, 7'h0);
    stat_is("R5 clear ignored while frozen", 32'h40);
    wr_ev(2'd2, 32'h40, 7'h0);
    rd(2'd2, v); chk("R5 enable write ignored while frozen", v, 32'h0);
    clk_freeze_i = 1'b0;
    sof_gen_off_i = 1'b0;
    wr_ev(2'd1, 32'h40, 7'h0);
    stat_is("R5 clear after thaw", 32'h0);

    // R3 pipe levels
    @(negedge clk) pipe_irq_i = 9'h105;
    #1 stat_is("R3 pipe levels live", 32'h0001_0500);
    wr_ev(2'd1, 32'hFFFF_FFFF, 7'h0);
    stat_is("R3 pipes ignore clear", 32'h0001_0500);
    @(negedge clk) pipe_irq_i = 9'h000;
    #1 stat_is("R3 pipes follow level down", 32'h0);

    // R9 set beats clear
    wr_ev(2'd1, 32'h4, 7'h04);
    stat_is("R9 set wins from clear", 32'h4);
    wr_ev(2'd1, 32'h4, 7'h04);
    stat_is("R9 set wins while already set", 32'h4);
    sof_gen_off_i = 1'b1;
    wr_ev(2'd1, 32'h50, 7'h10);
    stat_is("R9 wake set wins", 32'h54);
    sof_gen_off_i = 1'b0;
    wr_ev(2'd1, 32'h50, 7'h0);
    stat_is("R9 cleanup leaves reset flag", 32'h4);

    // R10 masking, R2 enable readback
    #1 chk("R10 irq low with enables off", {31'd0, irq_o}, 32'd0);
    wr_ev(2'd2, 32'h4, 7'h0);
    #1 chk("R10 irq high with matching enable", {31'd0, irq_o}, 32'd1);
    wr_ev(2'd2, 32'h8, 7'h0);
    #1 chk("R10 irq low with other enable", {31'd0, irq_o}, 32'd0);
    wr_ev(2'd2, 32'h0001_0000, 7'h0);
    @(negedge clk) pipe_irq_i = 9'h100;
    #1 chk("R10 irq from pipe 8", {31'd0, irq_o}, 32'd1);
    @(negedge clk) pipe_irq_i = 9'h000;
    #1 chk("R10 irq drops with pipe", {31'd0, irq_o}, 32'd0);
    wr_ev(2'd2, 32'hFFFF_FFFF, 7'h0);
    rd(2'd2, v); chk("R2 enable keeps defined bits only", v, 32'h0001_FF7F);
    rd(2'd3, v); chk("R2 spare address reads zero", v, 32'h0);
    wr_ev(2'd1, 32'h4, 7'h0);
    stat_is("R2 all clear at end", 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule